// File: doc/BRIEF.md
# SD Card Command Register Front-End

This block sits between a simple word-wide register bus and the command and data ports of an SD card host. Software programs a clock divider, an enable word and a start word. It then stages a six-byte command by writing one byte at a time to a single command register. When the sixth byte lands, the block presents the index, argument and CRC to the card side on a valid/ready request port. It then waits for the card side to return a response length and up to sixteen response bytes.

The returned bytes go into a seventeen-entry response buffer, which software drains one byte per read of the same command register. Byte 0 holds the command index. A sixteen-byte response instead gets the marker 0x3F in byte 0. A four-byte response is padded with a zero CRC byte. After an index-0 command, the block drops the next command byte, because that write only exists to clock the card's initialisation.

Data words written by software leave toward the card as four bytes, most significant first. Bytes arriving from the card are packed into the word that a data read returns. When no card is present, command and data reads return all ones and command and data writes do nothing.

Top module: `sd_reg_front`

## Requirements
- R1: Word offsets 0 (clock divider), 1 (enable) and 3 (start) store all 32 bits of a write and return them on read. Read data appears on busRdata on the clock edge that samples busRd and holds until the next read.
- R2: Offset 2 (pending) reads as enable bit 1 at bit 1 and enable bit 3 at bit 3, with every other bit 0. The value is recomputed from the enable bits on each write to offset 1 and on each write to offset 2.
- R3: Six accepted writes to offset 4 each store their low byte. After the sixth, cmdValid rises with cmdIndex = byte0[5:0], cmdArg = {byte1, byte2, byte3, byte4} and cmdCrc = byte5. These fields stay stable until a cycle with cmdReady high.
- R4: After a command with index 0 is issued, the next accepted write to offset 4 is discarded and does not count toward the six bytes.
- R5: A response pulse (rspValid) carrying n bytes (n other than 4 and 16) loads a buffer of length n+1. Byte 0 is the command index and byte k is rspData[8k-1:8k-8]. Successive reads of offset 4 return bytes 0, 1, … zero-extended to 32 bits.
- R6: For n = 16, byte 0 is 0x3F and the length is 17. For n = 4, byte 5 is 0x00 regardless of rspData and the length is 6.
- R7: A read of offset 4 at the position equal to the length returns 0 and wraps the read position to 0. It also sets rspOverrun, which stays high until the next response load clears it.
- R8: With cardPresent low, offset 4 reads return 0xFF and offset 5 reads return 0xFFFFFFFF. Writes to offsets 4 and 5 are ignored, and the command write position and response read position do not move.
- R9: A write to offset 5 drives datTxValid for four consecutive cycles starting the cycle after the write, with datTxByte carrying bits [31:24], [23:16], [15:8] and then [7:0]. A write to offset 5 during such a burst is ignored.
- R10: A read of offset 5 returns the last four bytes taken on datRxValid, the oldest in bits [31:24].
- R11: A read of offset 6 or 7 returns 0. Any access to offset 6 or 7 sets busErr, which stays high until reset.
- R12: After reset, offsets 0 to 3 read 0, busErr, cmdValid, datTxValid and rspOverrun are low, and the response length is 0. The first read of offset 4 therefore returns 0 and sets rspOverrun.
- R13: Writes to offset 4 while a command is outstanding (from cmdValid rising until the response pulse) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 3 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | Sticky flag for an access to an undefined offset |
| cardPresent | input | 1 | Card inserted |
| cmdValid | output | 1 | Command request valid |
| cmdReady | input | 1 | Card side accepts the request |
| cmdIndex | output | 6 | Command index |
| cmdArg | output | 32 | Command argument |
| cmdCrc | output | 8 | CRC field byte |
| rspValid | input | 1 | Response pulse |
| rspLen | input | 5 | Response byte count, 0 to 16 |
| rspData | input | 128 | Response bytes, byte k at bits [8k+7:8k] |
| rspOverrun | output | 1 | Sticky flag for a read past the response end |
| datTxValid | output | 1 | Outgoing data byte valid |
| datTxByte | output | 8 | Outgoing data byte |
| datRxValid | input | 1 | Incoming data byte valid |
| datRxByte | input | 8 | Incoming data byte |

## Verification
The bench sweeps every response length from 0 to 16. For each length it drains the buffer, reads once past the end and once after the wrap. A design that miscounts the length, skips the 0x3F prefix or the zero pad, or fails to wrap would return the wrong byte or leave rspOverrun low. Alignment faults show up as a request with the wrong index or argument on a later command: a failure to drop the byte after index 0, or extra bytes accepted while a command is outstanding or while no card is present. The data path checks byte order in both directions and checks that a second data write during a burst does not restart it.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int CMD_BYTES = 6;
  localparam int RSP_BYTES = 16;
  localparam int RSP_DEPTH = RSP_BYTES + 1;
  localparam int LEN_W = $clog2(RSP_DEPTH + 1);
  localparam int ADDR_W = 3;
  localparam int SLOT_W = $clog2(CMD_BYTES);
  localparam int WORD_W = 32;
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int TXC_W = $clog2(BYTES_PER_WORD + 1);

  localparam logic [ADDR_W-1:0] OFS_DIV   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_START = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DAT   = 3'd5;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_DIV, SEL_EN, SEL_PEND, SEL_START,
    SEL_RSP, SEL_CMD_FF, SEL_DAT, SEL_DAT_FF
  } rdSel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} cmdState_e;

  typedef struct packed {
    logic wrDiv;
    logic wrEn;
    logic wrPend;
    logic wrStart;
    logic cmdWr;
    logic [SLOT_W-1:0] cmdSlot;
    logic rspLoad;
    logic datWr;
    logic rdEn;
    rdSel_e rdSel;
    logic [LEN_W-1:0] rdIdx;
  } strobes_t;
endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [5:0]        wrIndexBits,
  input  logic              cardPresent,
  input  logic              cmdReady,
  input  logic              rspValid,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic              txBusy,
  output logic              cmdValid,
  output logic              rspOverrun,
  output logic              busErr,
  output strobes_t          stb
);
  cmdState_e state;
  logic [SLOT_W-1:0] wrPtr;
  logic [LEN_W-1:0]  rdPtr;
  logic [LEN_W-1:0]  lenQ;
  logic skipNext;
  logic zeroIdx;

  logic undefHit;
  logic cmdWrOk;
  logic cmdRdOk;
  logic rdPast;
  logic [LEN_W-1:0] lenCalc;

  assign undefHit = (busWr || busRd) && (busAddr > OFS_DAT);
  assign cmdWrOk  = busWr && (busAddr == OFS_CMD) && cardPresent && (state == ST_IDLE);
  assign cmdRdOk  = busRd && (busAddr == OFS_CMD) && cardPresent;
  assign rdPast   = (rdPtr >= lenQ);
  assign cmdValid = (state == ST_REQ);

  always_comb begin
    if (rspLen == LEN_W'(RSP_BYTES))
      lenCalc = LEN_W'(RSP_DEPTH);
    else if (rspLen == LEN_W'(4))
      lenCalc = LEN_W'(6);
    else
      lenCalc = rspLen + LEN_W'(1);
  end

  always_comb begin
    stb = '0;
    stb.wrDiv   = busWr && (busAddr == OFS_DIV);
    stb.wrEn    = busWr && (busAddr == OFS_EN);
    stb.wrPend  = busWr && (busAddr == OFS_PEND);
    stb.wrStart = busWr && (busAddr == OFS_START);
    stb.cmdWr   = cmdWrOk && !skipNext;
    stb.cmdSlot = wrPtr;
    stb.rspLoad = (state == ST_RSP) && rspValid;
    stb.datWr   = busWr && (busAddr == OFS_DAT) && cardPresent && !txBusy;
    stb.rdEn    = busRd;
    stb.rdIdx   = rdPtr;
    case (busAddr)
      OFS_DIV:   stb.rdSel = SEL_DIV;
      OFS_EN:    stb.rdSel = SEL_EN;
      OFS_PEND:  stb.rdSel = SEL_PEND;
      OFS_START: stb.rdSel = SEL_START;
      OFS_CMD:   stb.rdSel = !cardPresent ? SEL_CMD_FF : (rdPast ? SEL_ZERO : SEL_RSP);
      OFS_DAT:   stb.rdSel = cardPresent ? SEL_DAT : SEL_DAT_FF;
      default:   stb.rdSel = SEL_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      wrPtr      <= '0;
      rdPtr      <= '0;
      lenQ       <= '0;
      skipNext   <= 1'b0;
      zeroIdx    <= 1'b0;
      rspOverrun <= 1'b0;
      busErr     <= 1'b0;
    end else begin
      if (undefHit) busErr <= 1'b1;

      if (cmdWrOk) begin
        if (skipNext) begin
          skipNext <= 1'b0;
        end else begin
          if (wrPtr == '0) zeroIdx <= (wrIndexBits == 6'd0);
          if (wrPtr == SLOT_W'(CMD_BYTES - 1)) begin
            wrPtr    <= '0;
            state    <= ST_REQ;
            skipNext <= zeroIdx;
          end else begin
            wrPtr <= wrPtr + SLOT_W'(1);
          end
        end
      end

      if (cmdRdOk) begin
        if (rdPast) begin
          rdPtr      <= '0;
          rspOverrun <= 1'b1;
        end else begin
          rdPtr <= rdPtr + LEN_W'(1);
        end
      end

      case (state)
        ST_REQ: if (cmdReady) state <= ST_RSP;
        ST_RSP: if (rspValid) begin
          state      <= ST_IDLE;
          lenQ       <= lenCalc;
          rdPtr      <= '0;
          rspOverrun <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdf_dpath.sv
module sdf_dpath
  import sdf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              stb,
  input  logic [WORD_W-1:0]     busWdata,
  input  logic [LEN_W-1:0]      rspLen,
  input  logic [RSP_BYTES*8-1:0] rspData,
  input  logic                  datRxValid,
  input  logic [7:0]            datRxByte,
  output logic [5:0]            cmdIndex,
  output logic [31:0]           cmdArg,
  output logic [7:0]            cmdCrc,
  output logic                  datTxValid,
  output logic [7:0]            datTxByte,
  output logic                  txBusy,
  output logic [WORD_W-1:0]     busRdata
);
  logic [WORD_W-1:0] divQ, enQ, startQ;
  logic [1:0] pendQ;
  logic [7:0] rspBuf [RSP_DEPTH];
  logic [WORD_W-1:0] txShift, rxShift;
  logic [TXC_W-1:0] txCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ   <= '0;
      enQ    <= '0;
      startQ <= '0;
      pendQ  <= '0;
    end else begin
      if (stb.wrDiv)   divQ   <= busWdata;
      if (stb.wrStart) startQ <= busWdata;
      if (stb.wrEn) begin
        enQ   <= busWdata;
        pendQ <= {busWdata[3], busWdata[1]};
      end else if (stb.wrPend) begin
        pendQ <= {enQ[3], enQ[1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdIndex <= '0;
      cmdArg   <= '0;
      cmdCrc   <= '0;
    end else if (stb.cmdWr) begin
      case (stb.cmdSlot)
        3'd0: cmdIndex      <= busWdata[5:0];
        3'd1: cmdArg[31:24] <= busWdata[7:0];
        3'd2: cmdArg[23:16] <= busWdata[7:0];
        3'd3: cmdArg[15:8]  <= busWdata[7:0];
        3'd4: cmdArg[7:0]   <= busWdata[7:0];
        default: cmdCrc     <= busWdata[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspBuf[0] <= '0;
    end else if (stb.rspLoad) begin
      rspBuf[0] <= (rspLen == LEN_W'(RSP_BYTES)) ? 8'h3F : {2'b00, cmdIndex};
    end
  end

  for (genvar i = 1; i < RSP_DEPTH; i++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rspBuf[i] <= '0;
      end else if (stb.rspLoad) begin
        rspBuf[i] <= (LEN_W'(i) <= rspLen) ? rspData[8*(i-1) +: 8] : 8'h00;
      end
    end
  end

  assign txBusy     = (txCnt != '0);
  assign datTxValid = txBusy;
  assign datTxByte  = txShift[WORD_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      txCnt   <= '0;
      rxShift <= '0;
    end else begin
      if (stb.datWr) begin
        txShift <= busWdata;
        txCnt   <= TXC_W'(BYTES_PER_WORD);
      end else if (txBusy) begin
        txShift <= {txShift[WORD_W-9:0], 8'h00};
        txCnt   <= txCnt - TXC_W'(1);
      end
      if (datRxValid) rxShift <= {rxShift[WORD_W-9:0], datRxByte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdEn) begin
      case (stb.rdSel)
        SEL_DIV:    busRdata <= divQ;
        SEL_EN:     busRdata <= enQ;
        SEL_PEND:   busRdata <= {28'd0, pendQ[1], 1'b0, pendQ[0], 1'b0};
        SEL_START:  busRdata <= startQ;
        SEL_RSP:    busRdata <= {24'd0, rspBuf[stb.rdIdx]};
        SEL_CMD_FF: busRdata <= 32'h0000_00FF;
        SEL_DAT:    busRdata <= rxShift;
        SEL_DAT_FF: busRdata <= 32'hFFFF_FFFF;
        default:    busRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sd_reg_front.sv
module sd_reg_front
  import sdf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic                   busRd,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [WORD_W-1:0]      busWdata,
  output logic [WORD_W-1:0]      busRdata,
  output logic                   busErr,
  input  logic                   cardPresent,
  output logic                   cmdValid,
  input  logic                   cmdReady,
  output logic [5:0]             cmdIndex,
  output logic [31:0]            cmdArg,
  output logic [7:0]             cmdCrc,
  input  logic                   rspValid,
  input  logic [LEN_W-1:0]       rspLen,
  input  logic [RSP_BYTES*8-1:0] rspData,
  output logic                   rspOverrun,
  output logic                   datTxValid,
  output logic [7:0]             datTxByte,
  input  logic                   datRxValid,
  input  logic [7:0]             datRxByte
);
  strobes_t stb;
  logic txBusy;

  sdf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .wrIndexBits(busWdata[5:0]), .cardPresent(cardPresent), .cmdReady(cmdReady),
    .rspValid(rspValid), .rspLen(rspLen), .txBusy(txBusy), .cmdValid(cmdValid),
    .rspOverrun(rspOverrun), .busErr(busErr), .stb(stb)
  );

  sdf_dpath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .rspLen(rspLen),
    .rspData(rspData), .datRxValid(datRxValid), .datRxByte(datRxByte),
    .cmdIndex(cmdIndex), .cmdArg(cmdArg), .cmdCrc(cmdCrc),
    .datTxValid(datTxValid), .datTxByte(datTxByte), .txBusy(txBusy),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker
  import sdf_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   busWr,
  input logic                   busRd,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [WORD_W-1:0]      busRdata,
  input logic                   busErr,
  input logic                   cardPresent,
  input logic                   cmdValid,
  input logic                   cmdReady,
  input logic [5:0]             cmdIndex,
  input logic [31:0]            cmdArg,
  input logic [7:0]             cmdCrc,
  input logic                   datTxValid
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdIndex) && $stable(cmdArg) && $stable(cmdCrc));

  p_pend_tx_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr == OFS_PEND |=> busRdata[0] == 1'b0 && busRdata[2] == 1'b0 && busRdata[31:4] == 28'd0);

  p_cmd_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr == OFS_CMD && cardPresent |=> busRdata[31:8] == 24'd0);

  p_absent_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr == OFS_CMD && !cardPresent |=> busRdata == 32'h0000_00FF);

  p_absent_dat_r8: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr == OFS_DAT && !cardPresent |=> busRdata == 32'hFFFF_FFFF);

  p_absent_notx_r8: assert property (@(posedge clk) disable iff (!rstN)
    !datTxValid && busWr && busAddr == OFS_DAT && !cardPresent |=> !datTxValid);

  p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr > OFS_DAT |=> busRdata == 32'd0 && busErr);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> busErr);
endmodule

bind sd_reg_front sdf_checker u_chk (.*);

// File: tb/sim_sd_reg_front.sv
`timescale 1ns/1ps
module sim_sd_reg_front;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busErr;
  logic cardPresent = 1'b1;
  logic cmdValid;
  logic cmdReady = 1'b0;
  logic [5:0] cmdIndex;
  logic [31:0] cmdArg;
  logic [7:0] cmdCrc;
  logic rspValid = 1'b0;
  logic [4:0] rspLen = '0;
  logic [127:0] rspData = '0;
  logic rspOverrun;
  logic datTxValid;
  logic [7:0] datTxByte;
  logic datRxValid = 1'b0;
  logic [7:0] datRxByte = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sd_reg_front u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] dbyte(input int n, input int k);
    return 8'((n * 16 + k * 13 + 5) & 255);
  endfunction

  task automatic runCmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc,
                        input int n, input bit extra, input bit drain, input string tag);
    logic [31:0] v;
    int expLen;
    logic [7:0] e;
    wr(3'd4, {24'd0, 2'b01, idx});
    wr(3'd4, {24'hABCDEF, arg[31:24]});
    wr(3'd4, {24'd0, arg[23:16]});
    wr(3'd4, {24'd0, arg[15:8]});
    wr(3'd4, {24'd0, arg[7:0]});
    wr(3'd4, {24'd0, crc});
    chk(cmdValid == 1'b1, {tag, " R3 valid"}, {31'd0, cmdValid}, 1);
    chk(cmdIndex == idx, {tag, " R3 index"}, {26'd0, cmdIndex}, {26'd0, idx});
    chk(cmdArg == arg, {tag, " R3 arg"}, cmdArg, arg);
    chk(cmdCrc == crc, {tag, " R3 crc"}, {24'd0, cmdCrc}, {24'd0, crc});
    if (extra) begin
      wr(3'd4, 32'h5A); wr(3'd4, 32'hA5);
      chk(cmdValid && cmdArg == arg && cmdIndex == idx, {tag, " R13 hold"}, cmdArg, arg);
    end else begin
      step(); step();
      chk(cmdValid && cmdArg == arg, {tag, " R3 hold"}, cmdArg, arg);
    end
    cmdReady = 1'b1;
    step();
    cmdReady = 1'b0;
    rspValid = 1'b1; rspLen = 5'(n);
    for (int k = 0; k < 16; k++) rspData[8*k +: 8] = dbyte(n, k);
    step();
    rspValid = 1'b0;
    if (extra) begin
      step();
      chk(cmdValid == 1'b0, {tag, " R13 no extra request"}, {31'd0, cmdValid}, 0);
    end
    if (drain) begin
      expLen = (n == 16) ? 17 : (n == 4) ? 6 : n + 1;
      for (int j = 0; j < expLen; j++) begin
        if (j == 0) e = (n == 16) ? 8'h3F : {2'b00, idx};
        else if (j <= n) e = dbyte(n, j - 1);
        else e = 8'h00;
        rd(3'd4, v);
        chk(v == {24'd0, e}, (n == 16 || n == 4) ? {tag, " R6 byte"} : {tag, " R5 byte"}, v, {24'd0, e});
      end
      chk(rspOverrun == 1'b0, {tag, " R7 no overrun yet"}, {31'd0, rspOverrun}, 0);
      rd(3'd4, v);
      chk(v == 32'd0 && rspOverrun, {tag, " R7 past end"}, v, 0);
      rd(3'd4, v);
      e = (n == 16) ? 8'h3F : {2'b00, idx};
      chk(v == {24'd0, e}, {tag, " R7 wrapped"}, v, {24'd0, e});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      chk(v == 32'd0, "R12 reg reset", v, 0);
    end
    chk(!busErr && !cmdValid && !datTxValid && !rspOverrun, "R12 flags low",
        {28'd0, busErr, cmdValid, datTxValid, rspOverrun}, 0);
    rd(3'd4, v);
    chk(v == 32'd0 && rspOverrun, "R12 empty response", {v[30:0], rspOverrun}, 1);

    // R1 storage
    wr(3'd0, 32'h1234_5678); wr(3'd3, 32'hCAFE_0003); wr(3'd1, 32'h8000_000F);
    rd(3'd0, v); chk(v == 32'h1234_5678, "R1 divider", v, 32'h1234_5678);
    rd(3'd3, v); chk(v == 32'hCAFE_0003, "R1 start", v, 32'hCAFE_0003);
    rd(3'd1, v); chk(v == 32'h8000_000F, "R1 enable", v, 32'h8000_000F);

    // R2 pending sweep over all enable nibbles
    for (int en = 0; en < 16; en++) begin
      wr(3'd1, 32'(en));
      rd(3'd2, v);
      chk(v == 32'(en & 10), "R2 pending after enable", v, 32'(en & 10));
      wr(3'd2, 32'hF);
      rd(3'd2, v);
      chk(v == 32'(en & 10), "R2 pending after clear", v, 32'(en & 10));
    end

    // R11 undefined offsets
    chk(busErr == 1'b0, "R11 no error yet", {31'd0, busErr}, 0);
    rd(3'd6, v);
    chk(v == 32'd0 && busErr, "R11 offset 6", v, 0);
    rd(3'd7, v);
    chk(v == 32'd0 && busErr, "R11 offset 7", v, 0);

    // R9 transmit burst, second write ignored
    wr(3'd5, 32'hA1B2_C3D4);
    chk(datTxValid && datTxByte == 8'hA1, "R9 byte0", {24'd0, datTxByte}, 32'hA1);
    wr(3'd5, 32'h1111_1111);
    chk(datTxValid && datTxByte == 8'hB2, "R9 byte1", {24'd0, datTxByte}, 32'hB2);
    step();
    chk(datTxValid && datTxByte == 8'hC3, "R9 byte2", {24'd0, datTxByte}, 32'hC3);
    step();
    chk(datTxValid && datTxByte == 8'hD4, "R9 byte3", {24'd0, datTxByte}, 32'hD4);
    step();
    chk(!datTxValid, "R9 burst end", {31'd0, datTxValid}, 0);

    // R10 receive packing
    for (int k = 1; k <= 5; k++) begin
      datRxValid = 1'b1; datRxByte = 8'(k * 17);
      step();
    end
    datRxValid = 1'b0;
    rd(3'd5, v);
    chk(v == 32'h2233_4455, "R10 packed word", v, 32'h2233_4455);

    // R5 R6 R7 sweep over all response lengths; R13 at n=3
    for (int n = 0; n <= 16; n++) begin
      runCmd(6'(1 + n * 3), 32'h0102_0304 * 32'(n + 1), 8'(8'hC0 | n), n, n == 3, 1'b1, "sweep");
    end

    // R8 absent card; read position is 1 after the last wrap
    cardPresent = 1'b0;
    rd(3'd4, v); chk(v == 32'hFF, "R8 cmd read", v, 32'hFF);
    rd(3'd5, v); chk(v == 32'hFFFF_FFFF, "R8 dat read", v, 32'hFFFF_FFFF);
    wr(3'd4, 32'h11); wr(3'd4, 32'h22); wr(3'd4, 32'h33);
    chk(!cmdValid, "R8 no request", {31'd0, cmdValid}, 0);
    wr(3'd5, 32'hDEAD_BEEF);
    chk(!datTxValid, "R8 no transmit", {31'd0, datTxValid}, 0);
    step();
    chk(!datTxValid, "R8 no transmit later", {31'd0, datTxValid}, 0);
    cardPresent = 1'b1;
    rd(3'd4, v);
    chk(v == {24'd0, dbyte(16, 0)}, "R8 read position kept", v, {24'd0, dbyte(16, 0)});
    runCmd(6'd9, 32'h0BAD_F00D, 8'h77, 2, 1'b0, 1'b1, "R8 alignment");

    // R4 dummy byte after index 0
    runCmd(6'd0, 32'h0000_0000, 8'h95, 4, 1'b0, 1'b1, "cmd0");
    wr(3'd4, 32'hEE);
    chk(!cmdValid, "R4 dummy no request", {31'd0, cmdValid}, 0);
    runCmd(6'd7, 32'h0000_01AA, 8'h87, 4, 1'b0, 1'b1, "R4 after dummy");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule